// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banking

This block exposes a bank of configuration registers through a pair of byte-wide host addresses: one address carries an index, the next carries the data for the register that index names. A strap input chooses which of two base addresses the pair sits at. The port stays closed until the host writes the entry key byte twice back to back on the index address. A closing key shuts it again.

Once open, indexes below 0x30 reach a small global bank. This bank holds a device-select byte, three multi-function select bytes and fixed identification bytes. Indexes from 0x30 upward belong to the logical device named by the select byte. Index 0x30 is an enable bit that the block keeps for each device. Higher indexes are forwarded on a side register-file interface with one-cycle write and read strobes. The device's read data returns combinationally. Host reads are combinational, so a read always shows the state from before any write in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: Only `bus_addr` equal to the base (index port) or base+1 (data port) is decoded. The base is 0x002E when `base_sel` is 0 and 0x004E when it is 1. Every other address has no effect and reads 0xFF.
- R2: Two consecutive index-port writes of 0x87, made while the port is closed, open it. `unlocked` goes high in the cycle after the second write.
- R3: While one 0x87 is pending, any other index-port byte cancels the sequence. A later single 0x87 then does not open the port.
- R4: While the port is open, an index-port write of 0xAA closes it, and the index keeps its previous value. Any other index-port write stores the byte as the index.
- R5: While the port is closed, data-port writes change nothing, index-port bytes are not stored as the index, both ports read 0xFF, and the side interface stays idle.
- R6: While the port is open, an index-port read returns the current index.
- R7: Index 0x20 reads the device ID high byte and 0x21 the low byte. 0x22 reads the revision, 0x23 reads 0x19 and 0x24 reads 0x34. These registers ignore writes. Unassigned indexes below 0x30 read 0x00.
- R8: Index 0x07 (device select) and indexes 0x29, 0x2A, 0x2B (multi-function bytes) are readable and writable. `mfunc` presents them as {0x2B, 0x2A, 0x29}, with 0x29 in bits 7:0.
- R9: A write to index 0x30 sets the selected device's bit in `dev_en` from data bit 0, and ignores the other data bits. A read of 0x30 returns {7'b0, enable}.
- R10: For an index above 0x30 with a valid selection, a data-port write pulses `ld_wr` and a data-port read pulses `ld_rd`, in the same cycle. During these pulses, `ld_idx`, `ld_sel` and `ld_wdata` carry the index, the selection and the byte, and the host read returns `ld_rdata`.
- R11: When the select byte is NUM_LD or more, every access to index 0x30 and above is ignored and reads 0xFF.
- R12: When a write and a read fall in the same cycle, the read returns the value from before that write.
- R13: After reset the port is closed, and the index, the select byte, `mfunc` and `dev_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Base address strap: 0 gives 0x2E, 1 gives 0x4E |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| unlocked | output | 1 | Configuration access open |
| dev_en | output | NUM_LD | Enable bit per logical device |
| mfunc | output | 24 | Multi-function select bytes |
| ld_sel | output | 8 | Selected logical device |
| ld_idx | output | 8 | Register index inside the device bank |
| ld_wr | output | 1 | Device bank write strobe |
| ld_rd | output | 1 | Device bank read strobe |
| ld_wdata | output | 8 | Device bank write byte |
| ld_rdata | input | 8 | Device bank read byte |

## Verification
The colliding pair is a register update and a host read of the same port in one cycle. One case writes a new select byte through the data port while reading it. Another writes the closing key on the index port while reading the index. The bench model computes the read value from its own state before it applies the write. It then compares `bus_rdata` in that cycle and the updated outputs on the next negative edge. This confirms the read sees the old value and the write still takes effect.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    typedef struct packed {
        logic       idx_hit;
        logic       dat_hit;
        logic       idx_wr;
        logic       dat_wr;
        logic       dat_rd;
        logic [7:0] wdata;
    } port_req_t;

    localparam logic [7:0] KEY_ENTER    = 8'h87;
    localparam logic [7:0] KEY_EXIT     = 8'hAA;
    localparam logic [7:0] REG_LDSEL    = 8'h07;
    localparam logic [7:0] REG_DEVID_HI = 8'h20;
    localparam logic [7:0] REG_DEVID_LO = 8'h21;
    localparam logic [7:0] REG_REV      = 8'h22;
    localparam logic [7:0] REG_VEN_HI   = 8'h23;
    localparam logic [7:0] REG_VEN_LO   = 8'h24;
    localparam logic [7:0] REG_MF_FIRST = 8'h29;
    localparam int         MF_COUNT     = 3;
    localparam logic [7:0] REG_DEV_EN   = 8'h30;
    localparam logic [15:0] VENDOR_ID   = 16'h1934;
    localparam logic [7:0] IDLE_READ    = 8'hFF;

    function automatic logic in_bank(input logic [7:0] idx);
        return idx >= REG_DEV_EN;
    endfunction

    function automatic logic to_side(input logic [7:0] idx);
        return idx > REG_DEV_EN;
    endfunction

endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       key_open
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            KEY_IDLE: if (idx_wr && wdata == KEY_ENTER) state_d = KEY_HALF;
            KEY_HALF: if (idx_wr) state_d = (wdata == KEY_ENTER) ? KEY_OPEN : KEY_IDLE;
            KEY_OPEN: if (idx_wr && wdata == KEY_EXIT) state_d = KEY_IDLE;
            default:  state_d = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign key_open = (state_q == KEY_OPEN);

endmodule

// File: rtl/sio_glob_bank.sv
module sio_glob_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h0901,
    parameter logic [7:0]  DEV_REV = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  key_open,
    input  logic                  idx_wr,
    input  logic                  dat_wr,
    input  logic [7:0]            wdata,
    output logic [7:0]            idx_q,
    output logic [7:0]            sel_q,
    output logic [8*MF_COUNT-1:0] mfunc,
    output logic [7:0]            glob_rdata
);

    logic [7:0]          mf_q [MF_COUNT];
    logic [MF_COUNT-1:0] mf_we;
    logic                glob_wr;

    assign glob_wr = dat_wr && key_open && !in_bank(idx_q);

    for (genvar g = 0; g < MF_COUNT; g++) begin : g_mf
        assign mf_we[g]          = glob_wr && (idx_q == REG_MF_FIRST + 8'(g));
        assign mfunc[8*g +: 8]   = mf_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 8'h00;
            sel_q <= 8'h00;
            for (int i = 0; i < MF_COUNT; i++) mf_q[i] <= 8'h00;
        end else begin
            if (idx_wr && key_open && wdata != KEY_EXIT) idx_q <= wdata;
            if (glob_wr && idx_q == REG_LDSEL) sel_q <= wdata;
            for (int i = 0; i < MF_COUNT; i++)
                if (mf_we[i]) mf_q[i] <= wdata;
        end
    end

    always_comb begin
        glob_rdata = 8'h00;
        case (idx_q)
            REG_LDSEL:    glob_rdata = sel_q;
            REG_DEVID_HI: glob_rdata = DEV_ID[15:8];
            REG_DEVID_LO: glob_rdata = DEV_ID[7:0];
            REG_REV:      glob_rdata = DEV_REV;
            REG_VEN_HI:   glob_rdata = VENDOR_ID[15:8];
            REG_VEN_LO:   glob_rdata = VENDOR_ID[7:0];
            default:      glob_rdata = 8'h00;
        endcase
        for (int i = 0; i < MF_COUNT; i++)
            if (idx_q == REG_MF_FIRST + 8'(i)) glob_rdata = mf_q[i];
    end

endmodule

// File: rtl/sio_ldev_route.sv
module sio_ldev_route
    import sio_cfg_pkg::*;
#(
    parameter int NUM_LD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_open,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic              en_bit,
    input  logic [7:0]        idx_q,
    input  logic [7:0]        sel_q,
    input  logic [7:0]        ld_rdata,
    output logic [NUM_LD-1:0] dev_en,
    output logic              ld_wr,
    output logic              ld_rd,
    output logic [7:0]        bank_rdata
);

    localparam logic [7:0] LD_LIMIT = 8'(NUM_LD);

    logic [NUM_LD-1:0] en_q;
    logic [NUM_LD-1:0] en_we;
    logic [NUM_LD-1:0] sel_hot;
    logic              sel_ok;
    logic              en_wr;

    assign sel_ok = sel_q < LD_LIMIT;
    assign en_wr  = dat_wr && key_open && (idx_q == REG_DEV_EN);

    for (genvar g = 0; g < NUM_LD; g++) begin : g_dev
        assign sel_hot[g] = (sel_q == 8'(g));
        assign en_we[g]   = en_wr && sel_hot[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LD; i++)
                if (en_we[i]) en_q[i] <= en_bit;
        end
    end

    assign dev_en = en_q;
    assign ld_wr  = dat_wr && key_open && sel_ok && to_side(idx_q);
    assign ld_rd  = dat_rd && key_open && sel_ok && to_side(idx_q);

    always_comb begin
        if (!sel_ok)                  bank_rdata = IDLE_READ;
        else if (idx_q == REG_DEV_EN) bank_rdata = {7'b0, |(en_q & sel_hot)};
        else                          bank_rdata = ld_rdata;
    end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          NUM_LD   = 8,
    parameter logic [15:0] BASE_PRI = 16'h002E,
    parameter logic [15:0] BASE_ALT = 16'h004E,
    parameter logic [15:0] DEV_ID   = 16'h0901,
    parameter logic [7:0]  DEV_REV  = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_sel,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  unlocked,
    output logic [NUM_LD-1:0]     dev_en,
    output logic [8*MF_COUNT-1:0] mfunc,
    output logic [7:0]            ld_sel,
    output logic [7:0]            ld_idx,
    output logic                  ld_wr,
    output logic                  ld_rd,
    output logic [7:0]            ld_wdata,
    input  logic [7:0]            ld_rdata
);

    logic [ADDR_W-1:0] base_addr;
    port_req_t         req;
    logic              key_open;
    logic [7:0]        idx_q;
    logic [7:0]        sel_q;
    logic [7:0]        glob_rdata;
    logic [7:0]        bank_rdata;

    assign base_addr = base_sel ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);

    always_comb begin
        req.idx_hit = (bus_addr == base_addr);
        req.dat_hit = (bus_addr == base_addr + ADDR_W'(1));
        req.idx_wr  = req.idx_hit && bus_wr;
        req.dat_wr  = req.dat_hit && bus_wr;
        req.dat_rd  = req.dat_hit && bus_rd;
        req.wdata   = bus_wdata;
    end

    sio_key_seq u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (req.idx_wr),
        .wdata    (req.wdata),
        .key_open (key_open)
    );

    sio_glob_bank #(
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV)
    ) u_glob (
        .clk        (clk),
        .rst        (rst),
        .key_open   (key_open),
        .idx_wr     (req.idx_wr),
        .dat_wr     (req.dat_wr),
        .wdata      (req.wdata),
        .idx_q      (idx_q),
        .sel_q      (sel_q),
        .mfunc      (mfunc),
        .glob_rdata (glob_rdata)
    );

    sio_ldev_route #(
        .NUM_LD (NUM_LD)
    ) u_ldev (
        .clk        (clk),
        .rst        (rst),
        .key_open   (key_open),
        .dat_wr     (req.dat_wr),
        .dat_rd     (req.dat_rd),
        .en_bit     (req.wdata[0]),
        .idx_q      (idx_q),
        .sel_q      (sel_q),
        .ld_rdata   (ld_rdata),
        .dev_en     (dev_en),
        .ld_wr      (ld_wr),
        .ld_rd      (ld_rd),
        .bank_rdata (bank_rdata)
    );

    always_comb begin
        if (!key_open || !(req.idx_hit || req.dat_hit)) bus_rdata = IDLE_READ;
        else if (req.idx_hit)                          bus_rdata = idx_q;
        else if (in_bank(idx_q))                       bus_rdata = bank_rdata;
        else                                           bus_rdata = glob_rdata;
    end

    assign unlocked = key_open;
    assign ld_sel   = sel_q;
    assign ld_idx   = idx_q;
    assign ld_wdata = bus_wdata;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter int NUM_LD = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  idx_wr,
    input logic                  dat_wr,
    input logic                  any_hit,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  unlocked,
    input logic                  ld_wr,
    input logic                  ld_rd,
    input logic [7:0]            ld_sel,
    input logic [7:0]            ld_idx,
    input logic [NUM_LD-1:0]     dev_en,
    input logic [8*MF_COUNT-1:0] mfunc
);

    localparam logic [7:0] LD_LIMIT = 8'(NUM_LD);

    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(idx_wr && bus_wdata == KEY_ENTER));

    a_r4_exit_key: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr && bus_wdata == KEY_EXIT) |=> !unlocked);

    a_r5_closed_reads: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && any_hit) |-> bus_rdata == IDLE_READ);

    a_r5_closed_side_idle: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !(ld_wr || ld_rd));

    a_r10_side_index: assert property (@(posedge clk) disable iff (rst)
        (ld_wr || ld_rd) |-> ld_idx > REG_DEV_EN);

    a_r11_sel_range: assert property (@(posedge clk) disable iff (rst)
        (ld_wr || ld_rd) |-> ld_sel < LD_LIMIT);

    a_r9_en_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(dat_wr) |-> $stable(dev_en));

    a_r9_one_device: assert property (@(posedge clk) disable iff (rst)
        $countones(dev_en ^ $past(dev_en)) <= 1);

    a_r8_mf_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(dat_wr) |-> $stable(mfunc));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_LD(NUM_LD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .idx_wr    (req.idx_wr),
    .dat_wr    (req.dat_wr),
    .any_hit   (req.idx_hit || req.dat_hit),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .unlocked  (unlocked),
    .ld_wr     (ld_wr),
    .ld_rd     (ld_rd),
    .ld_sel    (ld_sel),
    .ld_idx    (ld_idx),
    .dev_en    (dev_en),
    .mfunc     (mfunc)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          NUM_LD     = 8;
    localparam logic [15:0] DEV_ID     = 16'h0901;
    localparam logic [7:0]  DEV_REV    = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_sel = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        unlocked;
    logic [NUM_LD-1:0] dev_en;
    logic [23:0] mfunc;
    logic [7:0]  ld_sel, ld_idx, ld_wdata, ld_rdata;
    logic        ld_wr, ld_rd;

    sio_cfg_port #(
        .ADDR_W (16), .NUM_LD (NUM_LD), .BASE_PRI (16'h002E), .BASE_ALT (16'h004E),
        .DEV_ID (DEV_ID), .DEV_REV (DEV_REV)
    ) uut (
        .clk (clk), .rst (rst), .base_sel (base_sel), .bus_addr (bus_addr),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .unlocked (unlocked), .dev_en (dev_en),
        .mfunc (mfunc), .ld_sel (ld_sel), .ld_idx (ld_idx), .ld_wr (ld_wr),
        .ld_rd (ld_rd), .ld_wdata (ld_wdata), .ld_rdata (ld_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Device-bank responder: a fixed function of selection and index
    assign ld_rdata = {ld_sel[3:0], 4'h0} ^ ld_idx;

    // Reference model state (0 closed, 1 one key seen, 2 open)
    int         m_st = 0;
    logic [7:0] m_idx = 8'h00;
    logic [7:0] m_sel = 8'h00;
    logic [7:0] m_en = 8'h00;
    logic [7:0] m_mf [3] = '{8'h00, 8'h00, 8'h00};
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_base();
        return base_sel ? 16'h004E : 16'h002E;
    endfunction

    function automatic logic [7:0] m_read(logic [15:0] a);
        logic [7:0] r;
        if (m_st != 2 || (a != m_base() && a != m_base() + 16'd1)) return 8'hFF;
        if (a == m_base()) return m_idx;
        if (m_idx >= 8'h30) begin
            if (m_sel >= 8'(NUM_LD)) return 8'hFF;
            if (m_idx == 8'h30) return {7'b0, m_en[m_sel[2:0]]};
            return {m_sel[3:0], 4'h0} ^ m_idx;
        end
        case (m_idx)
            8'h07: r = m_sel;
            8'h20: r = DEV_ID[15:8];
            8'h21: r = DEV_ID[7:0];
            8'h22: r = DEV_REV;
            8'h23: r = 8'h19;
            8'h24: r = 8'h34;
            8'h29: r = m_mf[0];
            8'h2A: r = m_mf[1];
            8'h2B: r = m_mf[2];
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic cyc(logic [15:0] a, bit wr, bit rd, logic [7:0] wd, string tag);
        bit side_ok, exp_lw, exp_lr;
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        #1;
        side_ok = (m_st == 2) && (a == m_base() + 16'd1) && (m_idx > 8'h30)
                  && (m_sel < 8'(NUM_LD));
        exp_lw = wr && side_ok;
        exp_lr = rd && side_ok;
        if (rd) chk(tag, "bus_rdata", 32'(bus_rdata), 32'(m_read(a)));
        chk(tag, "ld_wr", 32'(ld_wr), 32'(exp_lw));
        chk(tag, "ld_rd", 32'(ld_rd), 32'(exp_lr));
        if (exp_lw) begin
            chk(tag, "ld_idx", 32'(ld_idx), 32'(m_idx));
            chk(tag, "ld_wdata", 32'(ld_wdata), 32'(wd));
            chk(tag, "ld_sel", 32'(ld_sel), 32'(m_sel));
        end
        @(posedge clk);
        if (wr && a == m_base()) begin
            case (m_st)
                0: if (wd == 8'h87) m_st = 1;
                1: m_st = (wd == 8'h87) ? 2 : 0;
                default: if (wd == 8'hAA) m_st = 0; else m_idx = wd;
            endcase
        end else if (wr && a == m_base() + 16'd1 && m_st == 2) begin
            if (m_idx == 8'h07) m_sel = wd;
            if (m_idx >= 8'h29 && m_idx <= 8'h2B) m_mf[int'(m_idx) - 41] = wd;
            if (m_idx == 8'h30 && m_sel < 8'(NUM_LD)) m_en[m_sel[2:0]] = wd[0];
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk(tag, "unlocked", 32'(unlocked), 32'(m_st == 2));
        chk(tag, "dev_en", 32'(dev_en), 32'(m_en));
        chk(tag, "mfunc", 32'(mfunc), {8'h0, m_mf[2], m_mf[1], m_mf[0]});
    endtask

    task automatic idxw(logic [7:0] v, string tag);
        cyc(m_base(), 1'b1, 1'b0, v, tag);
    endtask

    task automatic datw(logic [7:0] v, string tag);
        cyc(m_base() + 16'd1, 1'b1, 1'b0, v, tag);
    endtask

    task automatic datr(string tag);
        cyc(m_base() + 16'd1, 1'b0, 1'b1, 8'h00, tag);
    endtask

    task automatic open_port(string tag);
        idxw(8'h87, tag);
        idxw(8'h87, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        chk("R13", "unlocked", 32'(unlocked), 32'h0);
        chk("R13", "dev_en", 32'(dev_en), 32'h0);
        chk("R13", "mfunc", 32'(mfunc), 32'h0);

        // R5: closed port reads 0xFF on both addresses, data writes ignored
        datr("R5");
        cyc(16'h002E, 1'b0, 1'b1, 8'h00, "R5");
        datw(8'h5A, "R5");

        // R1: keys at the wrong base and other addresses do nothing
        cyc(16'h004E, 1'b1, 1'b0, 8'h87, "R1");
        cyc(16'h004E, 1'b1, 1'b0, 8'h87, "R1");
        cyc(16'h002D, 1'b1, 1'b0, 8'h87, "R1");
        cyc(16'h002F, 1'b1, 1'b0, 8'h87, "R1");

        // R3: interrupted key sequence stays closed
        idxw(8'h87, "R3");
        idxw(8'h11, "R3");
        idxw(8'h87, "R3");
        idxw(8'h29, "R3");
        // R2: two consecutive keys open the port
        open_port("R2");
        cyc(16'h0030, 1'b0, 1'b1, 8'h00, "R1");

        // R6: index write and read-back; R13 index reset value
        cyc(m_base(), 1'b0, 1'b1, 8'h00, "R13");
        idxw(8'h29, "R6");
        cyc(m_base(), 1'b0, 1'b1, 8'h00, "R6");

        // R8: multi-function bytes
        datw(8'hC3, "R8");
        idxw(8'h2A, "R8"); datw(8'h5E, "R8");
        idxw(8'h2B, "R8"); datw(8'h71, "R8");
        datr("R8");
        idxw(8'h29, "R8"); datr("R8");

        // R5: closed again, data write to 0x29 ignored, index not stored
        idxw(8'hAA, "R4");
        datw(8'hEE, "R5");
        idxw(8'h2B, "R5");
        open_port("R5");
        datr("R5");
        cyc(m_base(), 1'b0, 1'b1, 8'h00, "R4");

        // R7: identification bytes, read-only
        for (int i = 8'h20; i <= 8'h25; i++) begin
            idxw(8'(i), "R7");
            datr("R7");
        end
        idxw(8'h20, "R7"); datw(8'h00, "R7"); datr("R7");
        idxw(8'h24, "R7"); datw(8'hFF, "R7"); datr("R7");
        idxw(8'h0F, "R7"); datw(8'h33, "R7"); datr("R7");

        // R8: device select
        idxw(8'h07, "R8"); datw(8'h02, "R8"); datr("R8");

        // R9: enables per device
        idxw(8'h30, "R9"); datw(8'hFE, "R9"); datr("R9");
        datw(8'hFF, "R9"); datr("R9");
        idxw(8'h07, "R9"); datw(8'h05, "R9");
        idxw(8'h30, "R9"); datr("R9"); datw(8'h01, "R9"); datr("R9");
        idxw(8'h07, "R9"); datw(8'h02, "R9");
        idxw(8'h30, "R9"); datw(8'h00, "R9"); datr("R9");

        // R10: side interface pass-through
        idxw(8'h07, "R10"); datw(8'h03, "R10");
        idxw(8'h60, "R10"); datw(8'hAB, "R10"); datr("R10");
        idxw(8'hF0, "R10"); datw(8'h12, "R10"); datr("R10");

        // R11: selection beyond the device count
        idxw(8'h07, "R11"); datw(8'h09, "R11");
        idxw(8'h30, "R11"); datw(8'h01, "R11"); datr("R11");
        idxw(8'h60, "R11"); datw(8'h44, "R11"); datr("R11");
        idxw(8'h07, "R11"); datw(8'h08, "R11");
        idxw(8'h30, "R11"); datw(8'h01, "R11"); datr("R11");

        // R12: write and read in the same cycle
        idxw(8'h07, "R12");
        cyc(m_base() + 16'd1, 1'b1, 1'b1, 8'h04, "R12");
        datr("R12");
        idxw(8'h60, "R12");
        cyc(m_base() + 16'd1, 1'b1, 1'b1, 8'h9C, "R12");
        cyc(m_base(), 1'b1, 1'b1, 8'hAA, "R12");
        cyc(m_base(), 1'b0, 1'b1, 8'h00, "R12");

        // R1: alternate base
        base_sel = 1'b1;
        cyc(16'h002E, 1'b1, 1'b0, 8'h87, "R1");
        cyc(16'h002E, 1'b1, 1'b0, 8'h87, "R1");
        open_port("R1");
        idxw(8'h21, "R1"); datr("R1");
        cyc(16'h002F, 1'b0, 1'b1, 8'h00, "R1");
        idxw(8'hAA, "R4");

        finish_run();
    end

endmodule